// File: doc/BRIEF.md
# Permission-Qualified Set-Associative Tag Store

This block is the tag directory of a cache controller. The directory is organised as sets of ways. Each way holds a line tag and a two-bit access permission. A controller gives it one command per cycle, together with a line address, a request type and a new permission value. Within the same cycle the block answers with the lookup result: whether the tag is present, a command-specific grant bit, an allocation error flag, the way concerned, the permission of the matched line, and the line address of the way the replacement policy would evict from the addressed set.

Lookups are purely combinational on the current contents. Every change of state (filling a way, dropping a line, rewriting a permission, updating the recency order) takes effect at the next rising clock edge. The replacement order is kept per set. A build-time parameter selects the policy: exact least-recently-used order, or a binary-tree pseudo-LRU. Data storage and protocol sequencing belong to the surrounding controller.

Top module: `perm_tag_store`

## Requirements
- R1: The set index is the IDX_W = log2(LINES/WAYS) address bits just above the OFF_W offset bits. The tag is the remaining upper bits. Offset bits never change a result.
- R2: `hit_o` is 1 only when a way of the addressed set holds the request tag and its permission is not not-present. Permission codes are not-present=0, invalid=1, read-only=2, read-write=3. `perm_o` gives the matched permission, or 0 when there is no hit.
- R3: For ACCESS (cmd 1), `ok_o` is 1 when the hit line is read-write, for any request type. It is also 1 when the hit line is read-only and the request is a load (0) or an instruction fetch (2). In every other case it is 0. Request type 1 is a store and 3 is any other request.
- R4: For TEST (cmd 2), `ok_o` equals `hit_o`, whatever the request type.
- R5: An ACCESS or TEST that hits makes the hit way most recently used, even when the access is refused.
- R6: For AVAIL (cmd 3), `ok_o` is 1 when the tag hits or when any way of the set is not-present.
- R7: ALLOC (cmd 4) takes the lowest-numbered not-present way, reported on `way_o`. The way is written with the request tag and permission invalid, and it becomes most recently used.
- R8: An ALLOC whose tag already hits, or whose set has no not-present way, raises `err_o` with `ok_o`=0 and leaves the contents unchanged.
- R9: For PROBE (cmd 6), `ok_o` is 1 only when no way of the set is not-present. `way_o` gives the replacement victim way.
- R10: With USE_PLRU=0, the victim is the way of the set touched least recently. After reset the order is way 0 newest through way WAYS-1 oldest. `victim_o` is {victim tag, set index, zero offset}.
- R11: With USE_PLRU=1, each set keeps a tree of WAYS-1 bits, all 0 after reset. The victim is found by walking from the root: a 0 bit leads to the lower half and a 1 bit to the upper half. A touch sets every node on the path of the touched way to point away from it.
- R12: FREE (cmd 5) makes the hit way not-present. SETPERM (cmd 7) writes `perm_i` into the hit way. Both report `ok_o`=`hit_o` and have no effect on a miss.
- R13: TOUCH (cmd 8) makes the hit way most recently used and reports `ok_o`=`hit_o`. Commands 0 and 9-15 do nothing and report `ok_o`=0.
- R14: After reset every way is not-present and every tag is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_i | input | 4 | Command code |
| req_type_i | input | 2 | Request type: load 0, store 1, fetch 2, other 3 |
| addr_i | input | ADDR_W | Line address |
| perm_i | input | 2 | Permission written by SETPERM |
| hit_o | output | 1 | Tag present with a permission other than not-present |
| ok_o | output | 1 | Command-specific grant |
| err_o | output | 1 | Allocation error |
| way_o | output | WAY_W | Matched, allocated or victim way |
| perm_o | output | 2 | Permission of the matched way |
| victim_o | output | ADDR_W | Line address of the replacement victim of the set |

## Verification
Two copies of the block, one for each replacement policy, receive the same stimulus. Their outputs are compared with an arithmetic model kept in the bench. One sweep walks every permission against every request type, which separates the read-only grant rule from the read-write rule and from TEST. Other sweeps fill every set way by way, push allocations into full sets, and send addresses with non-zero offsets. A refused access followed by a probe shows whether the recency update depends on the grant. A long pseudo-random mix of all commands over a small tag pool then forces frequent full sets, frees and refills. This separates the exact-order policy from the tree policy.

// File: rtl/tsd_pkg.sv
package tsd_pkg;

  typedef enum logic [3:0] {
    CMD_NOP     = 4'd0,
    CMD_ACCESS  = 4'd1,
    CMD_TEST    = 4'd2,
    CMD_AVAIL   = 4'd3,
    CMD_ALLOC   = 4'd4,
    CMD_FREE    = 4'd5,
    CMD_PROBE   = 4'd6,
    CMD_SETPERM = 4'd7,
    CMD_TOUCH   = 4'd8
  } tsd_cmd_e;

  typedef enum logic [1:0] {
    PERM_NP  = 2'd0,
    PERM_INV = 2'd1,
    PERM_RO  = 2'd2,
    PERM_RW  = 2'd3
  } tsd_perm_e;

  typedef enum logic [1:0] {
    REQ_LOAD  = 2'd0,
    REQ_STORE = 2'd1,
    REQ_FETCH = 2'd2,
    REQ_OTHER = 2'd3
  } tsd_req_e;

endpackage

// File: rtl/tsd_way_match.sv
module tsd_way_match
  import tsd_pkg::*;
#(
  parameter int WAYS  = 4,
  parameter int TAG_W = 8,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic [WAYS-1:0][TAG_W-1:0] tags_i,
  input  logic [WAYS-1:0][1:0]       perms_i,
  input  logic [TAG_W-1:0]           tag_i,
  output logic                       hit_o,
  output logic [WAY_W-1:0]           hit_way_o,
  output logic                       free_o,
  output logic [WAY_W-1:0]           free_way_o
);

  logic [WAYS-1:0] match_vec;
  logic [WAYS-1:0] empty_vec;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign empty_vec[w] = (perms_i[w] == PERM_NP);
    assign match_vec[w] = (tags_i[w] == tag_i) && !empty_vec[w];
  end

  // lowest index wins: scan downward so the last write is the lowest
  always_comb begin
    hit_o      = 1'b0;
    hit_way_o  = '0;
    free_o     = 1'b0;
    free_way_o = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (match_vec[w]) begin
        hit_o     = 1'b1;
        hit_way_o = WAY_W'(w);
      end
      if (empty_vec[w]) begin
        free_o     = 1'b1;
        free_way_o = WAY_W'(w);
      end
    end
  end

endmodule

// File: rtl/tsd_repl_lru.sv
module tsd_repl_lru #(
  parameter int SETS = 4,
  parameter int WAYS = 4,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             touch_en_i,
  input  logic [SET_W-1:0] touch_set_i,
  input  logic [WAY_W-1:0] touch_way_i,
  input  logic [SET_W-1:0] query_set_i,
  output logic [WAY_W-1:0] victim_way_o
);

  // rank 0 = newest, WAYS-1 = oldest
  logic [SETS-1:0][WAYS-1:0][WAY_W-1:0] rank_q, rank_d;
  logic [WAYS-1:0] oldest_vec;

  always_comb begin
    rank_d = rank_q;
    if (touch_en_i) begin
      for (int w = 0; w < WAYS; w++) begin
        if (WAY_W'(w) == touch_way_i) begin
          rank_d[touch_set_i][w] = '0;
        end else if (rank_q[touch_set_i][w] < rank_q[touch_set_i][touch_way_i]) begin
          rank_d[touch_set_i][w] = rank_q[touch_set_i][w] + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        for (int w = 0; w < WAYS; w++) begin
          rank_q[s][w] <= WAY_W'(w);
        end
      end
    end else if (touch_en_i) begin
      rank_q <= rank_d;
    end
  end

  for (genvar w = 0; w < WAYS; w++) begin : g_old
    assign oldest_vec[w] = (rank_q[query_set_i][w] == WAY_W'(WAYS - 1));
  end

  always_comb begin
    victim_way_o = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (oldest_vec[w]) victim_way_o = WAY_W'(w);
    end
  end

  AST_LRU_ONE_OLDEST: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(oldest_vec) == 1); // R10
  AST_LRU_TOUCH_NEWEST: assert property (@(posedge clk) disable iff (!rst_n)
    touch_en_i |=> rank_q[$past(touch_set_i)][$past(touch_way_i)] == '0); // R10

endmodule

// File: rtl/tsd_repl_plru.sv
module tsd_repl_plru #(
  parameter int SETS = 4,
  parameter int WAYS = 4,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS),
  localparam int LVL   = WAY_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             touch_en_i,
  input  logic [SET_W-1:0] touch_set_i,
  input  logic [WAY_W-1:0] touch_way_i,
  input  logic [SET_W-1:0] query_set_i,
  output logic [WAY_W-1:0] victim_way_o
);

  logic [SETS-1:0][WAYS-2:0] bits_q, bits_d;
  logic [WAY_W-1:0] t_node, v_node;
  logic             t_dir, v_dir;

  always_comb begin
    bits_d = bits_q;
    t_node = '0;
    t_dir  = 1'b0;
    if (touch_en_i) begin
      for (int l = 0; l < LVL; l++) begin
        t_dir = touch_way_i[LVL-1-l];
        bits_d[touch_set_i][t_node] = ~t_dir;
        t_node = (t_node << 1) + WAY_W'(1) + WAY_W'(t_dir);
      end
    end
  end

  always_comb begin
    victim_way_o = '0;
    v_node = '0;
    v_dir  = 1'b0;
    for (int l = 0; l < LVL; l++) begin
      v_dir = bits_q[query_set_i][v_node];
      victim_way_o[LVL-1-l] = v_dir;
      v_node = (v_node << 1) + WAY_W'(1) + WAY_W'(v_dir);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bits_q <= '0;
    end else if (touch_en_i) begin
      bits_q <= bits_d;
    end
  end

  AST_PLRU_ROOT_AWAY: assert property (@(posedge clk) disable iff (!rst_n)
    touch_en_i |=> bits_q[$past(touch_set_i)][0] == ~$past(touch_way_i[WAY_W-1])); // R11

endmodule

// File: rtl/perm_tag_store.sv
module perm_tag_store
  import tsd_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int OFF_W    = 2,
  parameter int LINES    = 16,
  parameter int WAYS     = 4,
  parameter bit USE_PLRU = 1'b0,
  localparam int SETS  = LINES / WAYS,
  localparam int IDX_W = $clog2(SETS),
  localparam int TAG_W = ADDR_W - OFF_W - IDX_W,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        cmd_i,
  input  logic [1:0]        req_type_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        perm_i,
  output logic              hit_o,
  output logic              ok_o,
  output logic              err_o,
  output logic [WAY_W-1:0]  way_o,
  output logic [1:0]        perm_o,
  output logic [ADDR_W-1:0] victim_o
);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [SETS-1:0][WAYS-1:0][TAG_W-1:0] tag_q, tag_d;
  logic [SETS-1:0][WAYS-1:0][1:0]       perm_q, perm_d;

  logic [IDX_W-1:0] set_idx;
  logic [TAG_W-1:0] req_tag;
  logic             hit, free_any;
  logic [WAY_W-1:0] hit_way, free_way, victim_way;
  logic             touch_en, alloc_we, free_we, perm_we, state_we;
  logic [WAY_W-1:0] touch_way;
  tsd_cmd_e         cmd;

  assign cmd     = tsd_cmd_e'(cmd_i);
  assign set_idx = addr_i[OFF_W +: IDX_W];
  assign req_tag = addr_i[ADDR_W-1 -: TAG_W];

  tsd_way_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_match (
    .tags_i     (tag_q[set_idx]),
    .perms_i    (perm_q[set_idx]),
    .tag_i      (req_tag),
    .hit_o      (hit),
    .hit_way_o  (hit_way),
    .free_o     (free_any),
    .free_way_o (free_way)
  );

  if (USE_PLRU) begin : g_plru
    tsd_repl_plru #(.SETS(SETS), .WAYS(WAYS)) u_repl (
      .clk          (clk),
      .rst_n        (rst_int_n),
      .touch_en_i   (touch_en),
      .touch_set_i  (set_idx),
      .touch_way_i  (touch_way),
      .query_set_i  (set_idx),
      .victim_way_o (victim_way)
    );
  end else begin : g_lru
    tsd_repl_lru #(.SETS(SETS), .WAYS(WAYS)) u_repl (
      .clk          (clk),
      .rst_n        (rst_int_n),
      .touch_en_i   (touch_en),
      .touch_set_i  (set_idx),
      .touch_way_i  (touch_way),
      .query_set_i  (set_idx),
      .victim_way_o (victim_way)
    );
  end

  // command decode
  always_comb begin
    ok_o     = 1'b0;
    touch_en = 1'b0;
    alloc_we = 1'b0;
    free_we  = 1'b0;
    perm_we  = 1'b0;
    way_o    = hit_way;
    unique case (cmd)
      CMD_ACCESS: begin
        ok_o = hit && ((perm_q[set_idx][hit_way] == PERM_RW) ||
                       ((perm_q[set_idx][hit_way] == PERM_RO) &&
                        (req_type_i == REQ_LOAD || req_type_i == REQ_FETCH)));
        touch_en = hit;
      end
      CMD_TEST: begin
        ok_o     = hit;
        touch_en = hit;
      end
      CMD_AVAIL: ok_o = hit || free_any;
      CMD_ALLOC: begin
        ok_o     = !hit && free_any;
        alloc_we = ok_o;
        touch_en = ok_o;
        way_o    = free_way;
      end
      CMD_FREE: begin
        ok_o    = hit;
        free_we = hit;
      end
      CMD_PROBE: begin
        ok_o  = !free_any;
        way_o = victim_way;
      end
      CMD_SETPERM: begin
        ok_o    = hit;
        perm_we = hit;
      end
      CMD_TOUCH: begin
        ok_o     = hit;
        touch_en = hit;
      end
      default: ok_o = 1'b0;
    endcase
  end

  assign touch_way = (cmd == CMD_ALLOC) ? free_way : hit_way;
  assign err_o     = (cmd == CMD_ALLOC) && !ok_o;
  assign hit_o     = hit;
  assign perm_o    = hit ? perm_q[set_idx][hit_way] : PERM_NP;
  assign victim_o  = {tag_q[set_idx][victim_way], set_idx, {OFF_W{1'b0}}};
  assign state_we  = alloc_we || free_we || perm_we;

  // next state of the directory arrays
  always_comb begin
    tag_d  = tag_q;
    perm_d = perm_q;
    if (alloc_we) begin
      tag_d[set_idx][free_way]  = req_tag;
      perm_d[set_idx][free_way] = PERM_INV;
    end
    if (free_we) perm_d[set_idx][hit_way] = PERM_NP;
    if (perm_we) perm_d[set_idx][hit_way] = perm_i;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      tag_q  <= '0;
      perm_q <= '0;
    end else if (state_we) begin
      tag_q  <= tag_d;
      perm_q <= perm_d;
    end
  end

  AST_ALLOC_FILLS: assert property (@(posedge clk) disable iff (!rst_int_n)
    (cmd_i == CMD_ALLOC && ok_o) |=>
      (tag_q[$past(set_idx)][$past(free_way)] == $past(req_tag)) &&
      (perm_q[$past(set_idx)][$past(free_way)] == PERM_INV)); // R7
  AST_ALLOC_ERR_HOLD: assert property (@(posedge clk) disable iff (!rst_int_n)
    err_o |=> $stable(perm_q) && $stable(tag_q)); // R8
  AST_FREE_DROPS: assert property (@(posedge clk) disable iff (!rst_int_n)
    (cmd_i == CMD_FREE && hit_o) |=> perm_q[$past(set_idx)][$past(hit_way)] == PERM_NP); // R12
  AST_GRANT_PERM: assert property (@(posedge clk) disable iff (!rst_int_n)
    (cmd_i == CMD_ACCESS && ok_o) |-> (perm_o == PERM_RW || perm_o == PERM_RO)); // R3
  AST_HIT_LIVE: assert property (@(posedge clk) disable iff (!rst_int_n)
    hit_o |-> perm_o != PERM_NP); // R2

endmodule

// File: tb/sim_perm_tag_store.sv
module sim_perm_tag_store;

  localparam int CLK_P  = 10;
  localparam int ADDR_W = 12;
  localparam int OFF_W  = 2;
  localparam int LINES  = 16;
  localparam int WAYS   = 4;
  localparam int SETS   = LINES / WAYS;
  localparam int IDX_W  = 2;
  localparam int TAG_W  = ADDR_W - OFF_W - IDX_W;
  localparam int WAY_W  = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0]        cmd = '0;
  logic [1:0]        rt = '0;
  logic [ADDR_W-1:0] addr = '0;
  logic [1:0]        pin = '0;

  logic              hit0, ok0, err0, hit1, ok1, err1;
  logic [WAY_W-1:0]  way0, way1;
  logic [1:0]        perm0, perm1;
  logic [ADDR_W-1:0] vic0, vic1;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  int mtag  [SETS][WAYS];
  int mperm [SETS][WAYS];
  int mrank [SETS][WAYS];
  int mbits [SETS][WAYS-1];

  always #(CLK_P/2) clk = ~clk;

  perm_tag_store #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .LINES(LINES), .WAYS(WAYS), .USE_PLRU(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_i(cmd), .req_type_i(rt), .addr_i(addr), .perm_i(pin),
    .hit_o(hit0), .ok_o(ok0), .err_o(err0), .way_o(way0), .perm_o(perm0), .victim_o(vic0));

  perm_tag_store #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .LINES(LINES), .WAYS(WAYS), .USE_PLRU(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .cmd_i(cmd), .req_type_i(rt), .addr_i(addr), .perm_i(pin),
    .hit_o(hit1), .ok_o(ok1), .err_o(err1), .way_o(way1), .perm_o(perm1), .victim_o(vic1));

  task automatic chk(input string rq, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d (t=%0t)", rq, what, act, exp, $time);
    end
  endtask

  function automatic int lru_victim(input int s);
    int v = 0;
    for (int w = 0; w < WAYS; w++) if (mrank[s][w] == WAYS - 1) v = w;
    return v;
  endfunction

  function automatic int plru_victim(input int s);
    int node = 0;
    int v = 0;
    for (int l = 0; l < WAY_W; l++) begin
      int d = mbits[s][node];
      v = v * 2 + d;
      node = 2 * node + 1 + d;
    end
    return v;
  endfunction

  task automatic model_touch(input int s, input int w);
    int r = mrank[s][w];
    int node = 0;
    for (int v = 0; v < WAYS; v++) begin
      if (v == w) mrank[s][v] = 0;
      else if (mrank[s][v] < r) mrank[s][v] = mrank[s][v] + 1;
    end
    for (int l = 0; l < WAY_W; l++) begin
      int d = (w >> (WAY_W - 1 - l)) & 1;
      mbits[s][node] = 1 - d;
      node = 2 * node + 1 + d;
    end
  endtask

  function automatic string req_of(input int c);
    case (c)
      1: return "R3";
      2: return "R4";
      3: return "R6";
      4: return "R7";
      5: return "R12";
      6: return "R9";
      7: return "R12";
      8: return "R13";
      default: return "R13";
    endcase
  endfunction

  // one command: drive at negedge, check before posedge, update model at posedge
  task automatic do_cmd(input int c, input int r, input int t, input int s,
                        input int p, input int ofs, input string rq);
    int hw = -1;
    int fw = -1;
    bit h, f, ok_e, err_e;
    int lv, pv, way_e, way_e1, perm_e;
    @(negedge clk);
    cmd  = 4'(c);
    rt   = 2'(r);
    pin  = 2'(p);
    addr = ADDR_W'((t << (OFF_W + IDX_W)) | (s << OFF_W) | ofs);
    #1;
    for (int w = 0; w < WAYS; w++) begin
      if (hw < 0 && mtag[s][w] == t && mperm[s][w] != 0) hw = w;
      if (fw < 0 && mperm[s][w] == 0) fw = w;
    end
    h = (hw >= 0);
    f = (fw >= 0);
    case (c)
      1: ok_e = h && (mperm[s][hw] == 3 || (mperm[s][hw] == 2 && (r == 0 || r == 2)));
      2, 5, 7, 8: ok_e = h;
      3: ok_e = h || f;
      4: ok_e = !h && f;
      6: ok_e = !f;
      default: ok_e = 1'b0;
    endcase
    err_e  = (c == 4) && !ok_e;
    lv     = lru_victim(s);
    pv     = plru_victim(s);
    way_e  = (c == 4) ? (f ? fw : 0) : (c == 6) ? lv : (h ? hw : 0);
    way_e1 = (c == 6) ? pv : way_e;
    perm_e = h ? mperm[s][hw] : 0;
    chk("R2", "hit", int'(hit0), int'(h));
    chk("R2", "perm", int'(perm0), perm_e);
    chk(rq, "ok", int'(ok0), int'(ok_e));
    chk("R8", "err", int'(err0), int'(err_e));
    chk(rq, "way", int'(way0), way_e);
    chk("R10", "victim lru", int'(vic0), (mtag[s][lv] << (IDX_W + OFF_W)) | (s << OFF_W));
    chk("R11", "victim plru", int'(vic1), (mtag[s][pv] << (IDX_W + OFF_W)) | (s << OFF_W));
    chk("R11", "way plru", int'(way1), way_e1);
    chk(rq, "ok plru", int'(ok1), int'(ok_e));
    // state update as at the next edge
    if (((c == 1 || c == 2 || c == 8) && h)) model_touch(s, hw);
    if (c == 4 && ok_e) begin
      mtag[s][fw]  = t;
      mperm[s][fw] = 1;
      model_touch(s, fw);
    end
    if (c == 5 && h) mperm[s][hw] = 0;
    if (c == 7 && h) mperm[s][hw] = p;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    bit [31:0] lfsr = 32'h1ACE_B00C;
    for (int s = 0; s < SETS; s++) begin
      for (int w = 0; w < WAYS; w++) begin
        mtag[s][w] = 0; mperm[s][w] = 0; mrank[s][w] = w;
      end
      for (int n = 0; n < WAYS - 1; n++) mbits[s][n] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R14: empty after reset, every set free and not probe-able
    for (int s = 0; s < SETS; s++) begin
      do_cmd(1, 0, 0, s, 0, 0, "R14");
      do_cmd(3, 0, 5, s, 0, 0, "R14");
      do_cmd(6, 0, 5, s, 0, 0, "R9");
    end

    // R7: fill every set way by way
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < WAYS; w++)
        do_cmd(4, 0, s * 16 + w + 1, s, 0, 0, "R7");

    // R8: duplicate tag and full set
    do_cmd(4, 0, 1, 0, 0, 0, "R8");
    do_cmd(4, 0, 200, 1, 0, 0, "R8");
    do_cmd(1, 0, 200, 1, 0, 0, "R8");

    // R1: tags are per set, offsets ignored
    for (int s = 0; s < SETS; s++)
      for (int t = 0; t < SETS; t++)
        do_cmd(2, 1, t * 16 + 2, s, 0, s, "R1");

    // R9/R10: probe every full set
    for (int s = 0; s < SETS; s++) do_cmd(6, 0, 99, s, 0, 0, "R9");

    // R3/R4: every permission against every request type
    for (int p = 1; p < 4; p++) begin
      do_cmd(7, 0, 1, 0, p, 0, "R12");
      for (int r = 0; r < 4; r++) begin
        do_cmd(1, r, 1, 0, 0, 0, "R3");
        do_cmd(2, r, 1, 0, 0, 0, "R4");
      end
    end
    do_cmd(7, 0, 2, 0, 0, 0, "R2");
    do_cmd(1, 1, 2, 0, 0, 0, "R2");
    do_cmd(3, 0, 77, 0, 0, 0, "R6");
    do_cmd(4, 0, 77, 0, 0, 0, "R7");

    // R5: refused access still refreshes recency
    do_cmd(6, 0, 0, 1, 0, 0, "R5");
    do_cmd(1, 1, 17, 1, 0, 0, "R5");
    do_cmd(6, 0, 0, 1, 0, 0, "R5");
    do_cmd(2, 3, 18, 1, 0, 0, "R5");
    do_cmd(6, 0, 0, 1, 0, 0, "R5");

    // R13: touch then probe
    for (int w = WAYS - 1; w >= 0; w--) begin
      do_cmd(8, 0, 32 + w + 1, 2, 0, 0, "R13");
      do_cmd(6, 0, 0, 2, 0, 0, "R13");
    end
    do_cmd(8, 0, 250, 2, 0, 0, "R13");
    do_cmd(0, 0, 33, 2, 0, 0, "R13");

    // R12: free, refill, free a missing tag
    do_cmd(5, 0, 35, 2, 0, 0, "R12");
    do_cmd(3, 0, 150, 2, 0, 0, "R6");
    do_cmd(4, 0, 150, 2, 0, 0, "R7");
    do_cmd(5, 0, 151, 3, 0, 0, "R12");
    do_cmd(6, 0, 0, 3, 0, 0, "R12");
    do_cmd(7, 0, 151, 3, 3, 0, "R12");
    do_cmd(1, 1, 49, 3, 0, 0, "R12");

    // mixed traffic over a small tag pool
    for (int i = 0; i < 1500; i++) begin
      int c, t, s, r, p;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      c = int'(lfsr[3:0]) % 9;
      t = 1 + int'(lfsr[11:4]) % 6;
      s = int'(lfsr[13:12]);
      r = int'(lfsr[15:14]);
      p = int'(lfsr[17:16]);
      do_cmd(c, r, t, s, p, int'(lfsr[19:18]), req_of(c));
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule